// File: doc/BRIEF.md
# Four-Way Read Cache with Critical-Word-First Refill

This block is the read side of a set-associative cache. It sits between a processor load port and a memory port that returns whole lines. Each request address is split into a tag, a set index, a word-in-line index and a byte-in-word offset. On a hit the requested word is shifted down by its byte offset and returned on the cycle after acceptance.

On a miss, the block picks a victim way in the addressed set and asks memory for the line. The request starts at the missing word. Memory then streams the line one word per beat, wrapping around the end of the line. The waiting load is answered from the first beat, while the other words of the line keep filling the victim way.

The block accepts no new request until the refill has finished. Victims are chosen from per-way age counters that track true least-recently-used order.

Top module: `cache_early_restart`

## Requirements
- R1: After reset, req_ready_o is 1 and rsp_valid_o and mem_req_valid_o are 0. Every line is invalid, so the first access to any address misses.
- R2: With default parameters the address fields are: bits [1:0] byte offset, bits [3:2] word in line, bits [7:4] set, bits [31:8] tag. Two addresses with the same tag and set share a line.
- R3: A request accepted while its line is present raises rsp_valid_o on the next cycle. No memory request is made for it.
- R4: A request accepted while its line is absent raises mem_req_valid_o on the next cycle. mem_req_addr_o is the request address with bits [1:0] cleared. Both are held until mem_req_ready_i is seen high at a clock edge.
- R5: After the memory request is taken, data beat k (k = 0..3, counted on mem_rvalid_i) fills word (critical word + k) mod 4 of the line. Gaps between beats are allowed.
- R6: rsp_valid_o rises on the cycle after beat 0, and carries the critical word. The response does not wait for the rest of the line.
- R7: req_ready_o is 0 from the cycle after a miss is accepted until the last beat has been taken. It is 1 on the cycle after the last beat.
- R8: Replacement is true LRU per set. An access makes its way the youngest. Ways that were younger than it age by one. A miss replaces the oldest way, and invalid ways count as older than any valid way.
- R9: rsp_data_o is the selected 32-bit word shifted right by 8 times the byte offset, with zeros shifted in at the top.
- R10: Each request produces exactly one single-cycle pulse on rsp_valid_o. Beats 1 to 3 of a refill produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request present |
| req_addr_i | input | 32 | Load byte address |
| req_ready_o | output | 1 | Request accepted when high together with req_valid_i |
| rsp_valid_o | output | 1 | Load data valid, one cycle |
| rsp_data_o | output | 32 | Aligned load data |
| mem_req_valid_o | output | 1 | Line refill request |
| mem_req_addr_o | output | 32 | Address of the critical word of the line |
| mem_req_ready_i | input | 1 | Memory takes the refill request |
| mem_rvalid_i | input | 1 | Refill data beat present |
| mem_rdata_i | input | 32 | Refill data word |

## Verification
Each result has a fixed due cycle:
- A hit response is due one cycle after acceptance.
- The memory request is due one cycle after a miss is accepted.
- The early response is due one cycle after beat 0.
- req_ready_o is due to return one cycle after the last beat.

The bench drives inputs at falling edges and samples at the next falling edge. Each sample therefore sees the result of exactly one rising edge.

The bench also checks the quiet cycles: no response during later beats, no second pulse after a hit, and ready held low during stalls. It predicts hit or miss with a timestamp LRU model, and computes every data word arithmetically from its address.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MREQ = 2'd1,
    ST_FILL = 2'd2
  } fill_st_e;
endpackage

// File: rtl/cache_tag_array.sv
module cache_tag_array #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_set_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             wr_valid_i
);
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_q[lk_set_i][w] && (tag_q[lk_set_i][w] == lk_tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) hit_way_o = WAY_W'(w);
  end
  assign hit_o = |match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_i) begin
      valid_q[wr_set_i][wr_way_i] <= wr_valid_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) tag_q[wr_set_i][wr_way_i] <= wr_tag_i;
  end

  // a tag may live in at most one way of a set
  a_r8_no_dup_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_set_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] upd_set_i,
  input  logic [WAY_W-1:0] upd_way_i
);
  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic [AGE_W-1:0] cur_age;

  assign cur_age = age_q[upd_set_i][upd_way_i];

  always_comb begin
    victim_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[rd_set_i][w] == AGE_W'(WAYS-1)) victim_o = WAY_W'(w);
  end

  // reset ages are distinct: way w starts with age w
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (upd_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == upd_way_i)           age_q[upd_set_i][w] <= '0;
        else if (age_q[upd_set_i][w] < cur_age) age_q[upd_set_i][w] <= age_q[upd_set_i][w] + 1'b1;
      end
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_chk
    logic [WAYS-1:0] young_f, old_f;
    always_comb begin
      for (int w = 0; w < WAYS; w++) begin
        young_f[w] = (age_q[s][w] == '0);
        old_f[w]   = (age_q[s][w] == AGE_W'(WAYS-1));
      end
    end
    a_r8_ages_unique: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(young_f) == 1) && ($countones(old_f) == 1));
  end

  a_r8_touch_youngest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (age_q[$past(upd_set_i)][$past(upd_way_i)] == '0));
endmodule

// File: rtl/cache_data_array.sv
module cache_data_array #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int WPL    = 4,
  parameter int WORD_W = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WOFF_W = $clog2(WPL)
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_set_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [WOFF_W-1:0] rd_word_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_set_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [WOFF_W-1:0] wr_word_i,
  input  logic [WORD_W-1:0] wr_data_i
);
  logic [WORD_W-1:0] mem_q [SETS][WAYS][WPL];

  assign rd_data_o = mem_q[rd_set_i][rd_way_i][rd_word_i];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_set_i][wr_way_i][wr_word_i] <= wr_data_i;
  end
endmodule

// File: rtl/cache_align.sv
module cache_align #(
  parameter int WORD_W = 32,
  localparam int BOFF_W = $clog2(WORD_W/8)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [BOFF_W-1:0] off_i,
  output logic [WORD_W-1:0] data_o
);
  assign data_o = word_i >> {off_i, 3'b000};
endmodule

// File: rtl/cache_early_restart.sv
module cache_early_restart
  import cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WPL    = 4,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic              mem_req_valid_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  localparam int BOFF_W = $clog2(WORD_W/8);
  localparam int WOFF_W = $clog2(WPL);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W;

  fill_st_e          state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WAY_W-1:0]  victim_q;
  logic [WOFF_W-1:0] beat_q;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;

  logic [BOFF_W-1:0] in_byte, q_byte;
  logic [WOFF_W-1:0] in_word, q_word;
  logic [IDX_W-1:0]  in_set, q_set;
  logic [TAG_W-1:0]  in_tag, q_tag;

  assign in_byte = req_addr_i[BOFF_W-1:0];
  assign in_word = req_addr_i[BOFF_W +: WOFF_W];
  assign in_set  = req_addr_i[BOFF_W+WOFF_W +: IDX_W];
  assign in_tag  = req_addr_i[ADDR_W-1 -: TAG_W];
  assign q_byte  = addr_q[BOFF_W-1:0];
  assign q_word  = addr_q[BOFF_W +: WOFF_W];
  assign q_set   = addr_q[BOFF_W+WOFF_W +: IDX_W];
  assign q_tag   = addr_q[ADDR_W-1 -: TAG_W];

  logic             lk_hit;
  logic [WAY_W-1:0] lk_way, victim;
  logic             accept, fill_beat, crit_beat, last_beat;
  logic [WORD_W-1:0] rd_data, al_src, al_out;
  logic [BOFF_W-1:0] al_off;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign fill_beat   = (state_q == ST_FILL) && mem_rvalid_i;
  assign crit_beat   = fill_beat && (beat_q == '0);
  assign last_beat   = fill_beat && (beat_q == WOFF_W'(WPL-1));

  cache_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_set_i   (in_set),
    .lk_tag_i   (in_tag),
    .hit_o      (lk_hit),
    .hit_way_o  (lk_way),
    .wr_i       ((accept && !lk_hit) || last_beat),
    .wr_set_i   (last_beat ? q_set : in_set),
    .wr_way_i   (last_beat ? victim_q : victim),
    .wr_tag_i   (q_tag),
    .wr_valid_i (last_beat)
  );

  cache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_set_i  (in_set),
    .victim_o  (victim),
    .upd_i     ((accept && lk_hit) || last_beat),
    .upd_set_i (last_beat ? q_set : in_set),
    .upd_way_i (last_beat ? victim_q : lk_way)
  );

  cache_data_array #(.SETS(SETS), .WAYS(WAYS), .WPL(WPL), .WORD_W(WORD_W)) u_data (
    .clk_i     (clk_i),
    .rd_set_i  (in_set),
    .rd_way_i  (lk_way),
    .rd_word_i (in_word),
    .rd_data_o (rd_data),
    .wr_i      (fill_beat),
    .wr_set_i  (q_set),
    .wr_way_i  (victim_q),
    .wr_word_i (q_word + beat_q),
    .wr_data_i (mem_rdata_i)
  );

  // critical beat bypasses the array straight into the aligner
  assign al_src = crit_beat ? mem_rdata_i : rd_data;
  assign al_off = crit_beat ? q_byte : in_byte;

  cache_align #(.WORD_W(WORD_W)) u_align (
    .word_i (al_src),
    .off_i  (al_off),
    .data_o (al_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      victim_q <= '0;
      beat_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept && !lk_hit) begin
          state_q  <= ST_MREQ;
          addr_q   <= req_addr_i;
          victim_q <= victim;
        end
        ST_MREQ: if (mem_req_ready_i) begin
          state_q <= ST_FILL;
          beat_q  <= '0;
        end
        ST_FILL: if (mem_rvalid_i) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= (accept && lk_hit) || crit_beat;
      if ((accept && lk_hit) || crit_beat) rsp_data_q <= al_out;
    end
  end

  assign rsp_valid_o     = rsp_valid_q;
  assign rsp_data_o      = rsp_data_q;
  assign mem_req_valid_o = (state_q == ST_MREQ);
  assign mem_req_addr_o  = {addr_q[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};

  a_r3_hit_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && lk_hit) |=> (rsp_valid_o && !mem_req_valid_o));
  a_r4_miss_requests: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !lk_hit) |=> (mem_req_valid_o && !rsp_valid_o));
  a_r4_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
  a_r7_busy_after_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !lk_hit) |=> !req_ready_o);
  a_r7_ready_after_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_beat |=> req_ready_o);
  a_r10_no_late_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_beat && !crit_beat) |=> !rsp_valid_o);
endmodule

// File: tb/cache_early_restart_tb.sv
module cache_early_restart_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, mem_req_valid;
  logic [31:0] rsp_data, mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  cache_early_restart dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .req_valid_i     (req_valid),
    .req_addr_i      (req_addr),
    .req_ready_o     (req_ready),
    .rsp_valid_o     (rsp_valid),
    .rsp_data_o      (rsp_data),
    .mem_req_valid_o (mem_req_valid),
    .mem_req_addr_o  (mem_req_addr),
    .mem_req_ready_i (mem_req_ready),
    .mem_rvalid_i    (mem_rvalid),
    .mem_rdata_i     (mem_rdata)
  );

  // reference model: per-way tag, valid flag and last-use timestamp
  logic [23:0] m_tag [16][4];
  bit          m_vld [16][4];
  int          m_use [16][4];
  int          t_now = 1;
  logic [31:0] lfsr  = 32'h1ACE_B00C;

  function automatic logic [31:0] mem_word(input logic [29:0] waddr);
    return ({2'b00, waddr} * 32'h9E37_79B1) ^ 32'h5A3C_0F96;
  endfunction

  function automatic logic [31:0] next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns the expected hit flag and updates the model
  function automatic bit model_access(input logic [31:0] a);
    int s = int'(a[7:4]);
    int victim = 0;
    int oldest = 32'h7FFF_FFFF;
    for (int w = 0; w < 4; w++) begin
      if (m_vld[s][w] && m_tag[s][w] == a[31:8]) begin
        m_use[s][w] = t_now++;
        return 1'b1;
      end
    end
    for (int w = 0; w < 4; w++) begin
      int u = m_vld[s][w] ? m_use[s][w] : 0;
      if (u < oldest) begin oldest = u; victim = w; end
    end
    m_vld[s][victim] = 1'b1;
    m_tag[s][victim] = a[31:8];
    m_use[s][victim] = t_now++;
    return 1'b0;
  endfunction

  task automatic access(input logic [31:0] a, input bit stall);
    bit          exp_hit = model_access(a);
    logic [31:0] exp_d   = mem_word(a[31:2]) >> (8 * a[1:0]);
    @(negedge clk);
    check(req_ready === 1'b1, "R7 ready high before request", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === exp_hit, "R8 hit/miss decision (R3 hit timing)", {31'b0, rsp_valid}, {31'b0, exp_hit});
    if (exp_hit) begin
      check(rsp_data === exp_d, "R9 aligned hit data (R2 fields)", rsp_data, exp_d);
      check(mem_req_valid === 1'b0, "R3 no memory request on hit", {31'b0, mem_req_valid}, 32'd0);
      @(negedge clk);
      check(rsp_valid === 1'b0, "R10 single response pulse", {31'b0, rsp_valid}, 32'd0);
    end else begin
      check(mem_req_valid === 1'b1, "R4 memory request raised", {31'b0, mem_req_valid}, 32'd1);
      check(mem_req_addr === {a[31:2], 2'b00}, "R4 critical word address", mem_req_addr, {a[31:2], 2'b00});
      check(req_ready === 1'b0, "R7 ready low after miss", {31'b0, req_ready}, 32'd0);
      if (stall) begin
        @(negedge clk);
        check(mem_req_valid === 1'b1 && mem_req_addr === {a[31:2], 2'b00}, "R4 request held", mem_req_addr, {a[31:2], 2'b00});
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      check(mem_req_valid === 1'b0, "R4 request dropped after handshake", {31'b0, mem_req_valid}, 32'd0);
      for (int k = 0; k < 4; k++) begin
        logic [1:0] wi = a[3:2] + 2'(k);
        if (stall && k == 2) begin
          @(negedge clk);
          check(req_ready === 1'b0 && rsp_valid === 1'b0, "R7 ready low in beat gap", {31'b0, req_ready}, 32'd0);
        end
        mem_rvalid = 1'b1;
        mem_rdata  = mem_word({a[31:4], wi});
        @(negedge clk);
        mem_rvalid = 1'b0;
        if (k == 0) begin
          check(rsp_valid === 1'b1, "R6 early response after beat 0", {31'b0, rsp_valid}, 32'd1);
          check(rsp_data === exp_d, "R6 R9 critical word data", rsp_data, exp_d);
        end else begin
          check(rsp_valid === 1'b0, "R10 no response on later beat", {31'b0, rsp_valid}, 32'd0);
        end
        if (k < 3) check(req_ready === 1'b0, "R7 ready low during fill", {31'b0, req_ready}, 32'd0);
        else       check(req_ready === 1'b1, "R7 ready back after last beat", {31'b0, req_ready}, 32'd1);
      end
    end
  endtask

  // R5: after a fill, every other word of the line must hit with correct data
  task automatic sweep_line(input logic [31:0] base);
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 4; b++)
        access({base[31:4], 2'(w), 2'(b)}, 1'b0);
  endtask

  initial begin
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin
        m_vld[s][w] = 1'b0; m_use[s][w] = 0; m_tag[s][w] = '0;
      end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready === 1'b1, "R1 ready after reset", {31'b0, req_ready}, 32'd1);
    check(rsp_valid === 1'b0, "R1 no response in reset", {31'b0, rsp_valid}, 32'd0);
    check(mem_req_valid === 1'b0, "R1 no memory request in reset", {31'b0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0,
          "R1 idle after reset release", {31'b0, req_ready}, 32'd1);

    // R5 R9: fill from the last word (wrap) and sweep all words and bytes
    access(32'h0001_230E, 1'b1);
    sweep_line(32'h0001_2300);
    // R2: same set, different tag, lands in a different way
    access(32'h0002_2305, 1'b0);
    sweep_line(32'h0002_2300);

    // R8 directed: set 5, tags A..D fill, A touched, E evicts B, B evicts C
    access(32'h00A0_0050, 1'b0);
    access(32'h00B0_0054, 1'b0);
    access(32'h00C0_0058, 1'b1);
    access(32'h00D0_005C, 1'b0);
    access(32'h00A0_0051, 1'b0);
    access(32'h00E0_0052, 1'b0);
    access(32'h00B0_0053, 1'b0);
    access(32'h00A0_005F, 1'b0);
    access(32'h00D0_0050, 1'b0);
    access(32'h00E0_0054, 1'b0);
    access(32'h00C0_0058, 1'b1);

    // near-exhaustive mix: 6 tags x 4 sets, random word, byte and stalls
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r = next_rand();
      logic [23:0] tg = 24'h300 + 24'(r[2:0] % 6) * 24'h0A1;
      access({tg, 2'b00, r[5:4], r[7:6], r[9:8]}, r[12]);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule